// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by walking a two-level page table that sits in ordinary memory. The page number (the upper 20 bits of the address) is cut into two 10-bit indices. The upper index selects a 32-bit entry in an outer table, whose start address comes from a table base input. That entry names the inner table. The lower index then selects an entry in the inner table, and that entry supplies the physical frame. The low 12 address bits pass straight through as the byte offset within the page.

The walker accepts one request at a time. While the walk runs it holds a single-word read request on a request/response memory port. It waits as long as needed for each response. If either entry lacks its valid bit, it ends the walk with a one-cycle fault pulse that states which level failed. If both entries are valid, it ends with a one-cycle completion pulse and holds the physical address and the access permissions for the caller to read.

Entry layout used at both levels: bit 0 is the valid flag, bits 3:1 are the read/write/execute permission bits, and bits 31:12 hold either the inner table's 4 KiB-aligned base or the physical frame number. Bits 11:4 are ignored.

Top module: `pt_walker`

## Requirements
- R1: While reset is held and directly after it, the walker is idle: `req_ready`=1, `mem_rd_valid`=0, `done`=0, `fault`=0.
- R2: `req_ready` is 1 only while idle. A request is taken only when `req_valid` and `req_ready` are both 1. Any `req_valid` seen while a walk is in progress is ignored, and the walk goes on with the address it captured.
- R3: In the cycle after a request is taken, `mem_rd_valid`=1 with `mem_rd_addr` = `tbl_base` + 4 × vaddr[31:22], using the base captured at acceptance.
- R4: After a valid outer entry E, the next read has `mem_rd_addr` = {E[31:12], 12'h000} + 4 × vaddr[21:12].
- R5: An outer entry with bit 0 = 0 gives `fault`=1 in the next cycle with `fault_level`=0, and no inner read is issued.
- R6: An inner entry with bit 0 = 0 gives `fault`=1 in the next cycle with `fault_level`=1.
- R7: An inner entry I with bit 0 = 1 gives `done`=1 in the next cycle, with `paddr` = {I[31:12], vaddr[11:0]} and `perm` = I[3:1]. Both values hold until the next successful walk.
- R8: `done` and `fault` each last exactly one cycle. They are never high together and never high while a read is pending. The walker returns to idle in the cycle after either pulse.
- R9: A `mem_rsp_valid` pulse while no read is pending is ignored: no pulse follows, no read starts, and `paddr` does not change.
- R10: Each read request is held with a stable address for any number of cycles until `mem_rsp_valid` arrives, including a response in the very first cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to `clk` |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | 32 | Virtual address to translate |
| tbl_base | input | 32 | Byte address of the outer table, sampled when a request is taken |
| req_ready | output | 1 | High while idle; a request is taken when this and `req_valid` are high |
| mem_rd_valid | output | 1 | Read request to memory, held until the response |
| mem_rd_addr | output | 32 | Byte address of the table entry being read |
| mem_rsp_valid | input | 1 | Read data is present this cycle |
| mem_rsp_data | input | 32 | Table entry returned by memory |
| done | output | 1 | One-cycle pulse: translation completed |
| fault | output | 1 | One-cycle pulse: invalid entry found |
| fault_level | output | 1 | Level of the last fault: 0 = outer, 1 = inner |
| paddr | output | 32 | Physical address of the last successful walk |
| perm | output | 3 | Permission bits of the last successful walk |

## Verification
The assertions assume that memory answers only while `mem_rd_valid` is high and gives exactly one response per read. They also assume `paddr`, `perm` and `fault_level` are read only alongside their pulse. The bench acts as the memory. It drives `mem_rsp_valid` for a single cycle after a chosen wait of zero to three cycles. The single exception is a deliberate stray-response test in idle, which the walker must ignore. The entry contents come from arithmetic functions of the two indices, so the sweep reaches invalid outer entries, invalid inner entries and valid paths under two table bases. One of those bases is not page-aligned.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

  // Walk sequencer states
  typedef enum logic [2:0] {
    WS_IDLE  = 3'd0,
    WS_OUTER = 3'd1,
    WS_INNER = 3'd2,
    WS_DONE  = 3'd3,
    WS_FAULT = 3'd4
  } walk_state_e;

  // Table entry field positions (same at both levels)
  localparam int unsigned ENT_VALID_BIT = 0;
  localparam int unsigned ENT_PERM_LSB  = 1;
  localparam int unsigned ENT_PERM_W    = 3;

  // Number of table levels walked
  localparam int unsigned WALK_LEVELS   = 2;

endpackage

// File: rtl/ptw_fsm.sv
module ptw_fsm
  import pt_walker_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        rsp_valid,
  input  logic        entry_ok,
  output walk_state_e state_q
);

  walk_state_e state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      WS_IDLE:  if (start)     state_d = WS_OUTER;
      WS_OUTER: if (rsp_valid) state_d = entry_ok ? WS_INNER : WS_FAULT;
      WS_INNER: if (rsp_valid) state_d = entry_ok ? WS_DONE  : WS_FAULT;
      WS_DONE:                 state_d = WS_IDLE;
      WS_FAULT:                state_d = WS_IDLE;
      default:                 state_d = WS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= WS_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/ptw_entry_decode.sv
module ptw_entry_decode
  import pt_walker_pkg::*;
#(
  parameter int unsigned ENT_W = 32,
  parameter int unsigned OFF_W = 12
) (
  input  logic [ENT_W-1:0]       entry,
  output logic                   valid,
  output logic [ENT_PERM_W-1:0]  perm,
  output logic [ENT_W-OFF_W-1:0] frame
);

  localparam int unsigned RSVD_LSB = ENT_PERM_LSB + ENT_PERM_W;

  // Bits between the permissions and the frame carry no meaning
  logic rsvd_unused;

  assign valid       = entry[ENT_VALID_BIT];
  assign perm        = entry[ENT_PERM_LSB +: ENT_PERM_W];
  assign frame       = entry[ENT_W-1:OFF_W];
  assign rsvd_unused = ^entry[OFF_W-1:RSVD_LSB];

endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
  import pt_walker_pkg::*;
#(
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned AW     = 32,
  parameter int unsigned ENT_SH = 2
) (
  input  logic [WALK_LEVELS*IDX_W-1:0] vpn,
  input  logic [AW-1:0]                root_base,
  input  logic [AW-1:0]                leaf_base,
  input  logic                         sel_inner,
  output logic [AW-1:0]                rd_addr
);

  localparam int unsigned VPN_W = WALK_LEVELS * IDX_W;
  localparam int unsigned PAD_W = AW - IDX_W - ENT_SH;

  logic [IDX_W-1:0] idx [WALK_LEVELS];
  logic [IDX_W-1:0] idx_sel;
  logic [AW-1:0]    base_sel;
  logic [AW-1:0]    byte_off;

  // Level 0 takes the most significant index field
  for (genvar lv = 0; lv < WALK_LEVELS; lv++) begin : g_idx
    assign idx[lv] = vpn[VPN_W-1-lv*IDX_W -: IDX_W];
  end

  always_comb begin
    idx_sel  = sel_inner ? idx[1] : idx[0];
    base_sel = sel_inner ? leaf_base : root_base;
    byte_off = {{PAD_W{1'b0}}, idx_sel, {ENT_SH{1'b0}}};
    rd_addr  = base_sel + byte_off;
  end

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int unsigned IDX_W = 10,
  parameter int unsigned OFF_W = 12,
  parameter int unsigned ENT_W = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  input  logic [2*IDX_W+OFF_W-1:0]      req_vaddr,
  input  logic [ENT_W-1:0]              tbl_base,
  output logic                          req_ready,
  output logic                          mem_rd_valid,
  output logic [ENT_W-1:0]              mem_rd_addr,
  input  logic                          mem_rsp_valid,
  input  logic [ENT_W-1:0]              mem_rsp_data,
  output logic                          done,
  output logic                          fault,
  output logic                          fault_level,
  output logic [ENT_W-1:0]              paddr,
  output logic [ENT_PERM_W-1:0]         perm
);

  localparam int unsigned VA_W    = WALK_LEVELS * IDX_W + OFF_W;
  localparam int unsigned VPN_W   = VA_W - OFF_W;
  localparam int unsigned PA_W    = ENT_W;
  localparam int unsigned FRAME_W = ENT_W - OFF_W;
  localparam int unsigned ENT_SH  = $clog2(ENT_W / 8);

  walk_state_e state_q;

  logic in_idle, in_outer, in_inner;
  logic start, rsp_take;

  logic                  ent_valid;
  logic [ENT_PERM_W-1:0] ent_perm;
  logic [FRAME_W-1:0]    ent_frame;

  // Captured request and walk results
  logic [VA_W-1:0]       va_q;
  logic [PA_W-1:0]       root_q;
  logic [PA_W-1:0]       leaf_q,  leaf_d;
  logic [PA_W-1:0]       paddr_q, paddr_d;
  logic [ENT_PERM_W-1:0] perm_q;
  logic                  flvl_q,  flvl_d;
  logic                  req_en, leaf_en, res_en, flvl_en;

  ptw_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .rsp_valid (mem_rsp_valid),
    .entry_ok  (ent_valid),
    .state_q   (state_q)
  );

  ptw_entry_decode #(
    .ENT_W (ENT_W),
    .OFF_W (OFF_W)
  ) u_dec (
    .entry (mem_rsp_data),
    .valid (ent_valid),
    .perm  (ent_perm),
    .frame (ent_frame)
  );

  ptw_addr_gen #(
    .IDX_W  (IDX_W),
    .AW     (PA_W),
    .ENT_SH (ENT_SH)
  ) u_addr (
    .vpn       (va_q[VA_W-1:OFF_W]),
    .root_base (root_q),
    .leaf_base (leaf_q),
    .sel_inner (in_inner),
    .rd_addr   (mem_rd_addr)
  );

  // Enables and next values
  always_comb begin
    in_idle  = (state_q == WS_IDLE);
    in_outer = (state_q == WS_OUTER);
    in_inner = (state_q == WS_INNER);
    start    = req_valid && in_idle;
    rsp_take = mem_rsp_valid && (in_outer || in_inner);

    req_en   = start;
    leaf_en  = rsp_take && in_outer && ent_valid;
    res_en   = rsp_take && in_inner && ent_valid;
    flvl_en  = rsp_take && !ent_valid;

    leaf_d   = {ent_frame, {OFF_W{1'b0}}};
    paddr_d  = {ent_frame, va_q[OFF_W-1:0]};
    flvl_d   = in_inner;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_q    <= '0;
      root_q  <= '0;
      leaf_q  <= '0;
      paddr_q <= '0;
      perm_q  <= '0;
      flvl_q  <= 1'b0;
    end else begin
      if (req_en) begin
        va_q   <= req_vaddr;
        root_q <= tbl_base;
      end
      if (leaf_en) leaf_q <= leaf_d;
      if (res_en) begin
        paddr_q <= paddr_d;
        perm_q  <= ent_perm;
      end
      if (flvl_en) flvl_q <= flvl_d;
    end
  end

  assign req_ready    = in_idle;
  assign mem_rd_valid = in_outer || in_inner;
  assign done         = (state_q == WS_DONE);
  assign fault        = (state_q == WS_FAULT);
  assign fault_level  = flvl_q;
  assign paddr        = paddr_q;
  assign perm         = perm_q;

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk
  import pt_walker_pkg::*;
#(
  parameter int unsigned IDX_W = 10,
  parameter int unsigned OFF_W = 12,
  parameter int unsigned ENT_W = 32
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     req_valid,
  input logic [2*IDX_W+OFF_W-1:0] req_vaddr,
  input logic [ENT_W-1:0]         tbl_base,
  input logic                     req_ready,
  input logic                     mem_rd_valid,
  input logic [ENT_W-1:0]         mem_rd_addr,
  input logic                     mem_rsp_valid,
  input logic [ENT_W-1:0]         mem_rsp_data,
  input logic                     done,
  input logic                     fault,
  input logic                     fault_level,
  input logic [ENT_W-1:0]         paddr,
  input logic [ENT_PERM_W-1:0]    perm
);

  localparam int unsigned VA_W   = 2 * IDX_W + OFF_W;
  localparam int unsigned ENT_SH = $clog2(ENT_W / 8);
  localparam int unsigned PAD_W  = ENT_W - IDX_W - ENT_SH;
  localparam int unsigned RSVD_LSB = ENT_PERM_LSB + ENT_PERM_W;

  logic             seen_rst_q;
  logic [OFF_W-1:0] off_q;
  logic             chk_unused;

  assign chk_unused = ^mem_rsp_data[OFF_W-1:RSVD_LSB];

  always_ff @(posedge clk) seen_rst_q <= !rst_n;

  always_ff @(posedge clk) begin
    if (req_ready && req_valid) off_q <= req_vaddr[OFF_W-1:0];
  end

  // R1: idle outputs during reset
  always @(posedge clk) begin
    if (!rst_n && seen_rst_q) begin
      p_reset_idle_r1: assert (req_ready && !mem_rd_valid && !done && !fault)
        else $error("p_reset_idle_r1");
    end
  end

  p_ready_no_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_rd_valid);

  p_accept_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && req_valid) |=> mem_rd_valid &&
      (mem_rd_addr == $past(tbl_base) +
        {{PAD_W{1'b0}}, $past(req_vaddr[VA_W-1 -: IDX_W]), {ENT_SH{1'b0}}}));

  p_read_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rsp_valid) |=> mem_rd_valid && $stable(mem_rd_addr));

  p_outer_fault_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !fault_level) |->
      $past(mem_rd_valid && mem_rsp_valid && !mem_rsp_data[ENT_VALID_BIT]));

  p_inner_fault_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && fault_level) |->
      $past(mem_rd_valid && mem_rsp_valid && !mem_rsp_data[ENT_VALID_BIT]));

  p_done_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (paddr == {$past(mem_rsp_data[ENT_W-1:OFF_W]), off_q}) &&
             (perm == $past(mem_rsp_data[ENT_PERM_LSB +: ENT_PERM_W])));

  p_pulse_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fault));

  p_done_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && req_ready);

  p_fault_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> !fault && req_ready);

  p_quiet_in_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> !done && !fault);

endmodule

bind pt_walker pt_walker_chk #(
  .IDX_W (IDX_W),
  .OFF_W (OFF_W),
  .ENT_W (ENT_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_vaddr     (req_vaddr),
  .tbl_base      (tbl_base),
  .req_ready     (req_ready),
  .mem_rd_valid  (mem_rd_valid),
  .mem_rd_addr   (mem_rd_addr),
  .mem_rsp_valid (mem_rsp_valid),
  .mem_rsp_data  (mem_rsp_data),
  .done          (done),
  .fault         (fault),
  .fault_level   (fault_level),
  .paddr         (paddr),
  .perm          (perm)
);

// File: tb/pt_walker_tb_top.sv
module pt_walker_tb_top;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [31:0] req_vaddr;
  logic [31:0] tbl_base;
  logic        req_ready;
  logic        mem_rd_valid;
  logic [31:0] mem_rd_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;
  logic        done;
  logic        fault;
  logic        fault_level;
  logic [31:0] paddr;
  logic [2:0]  perm;

  int total;
  int bad;
  bit finished;

  localparam logic [31:0] LEAF_REGION = 32'h0100_0000;

  pt_walker dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_vaddr     (req_vaddr),
    .tbl_base      (tbl_base),
    .req_ready     (req_ready),
    .mem_rd_valid  (mem_rd_valid),
    .mem_rd_addr   (mem_rd_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .done          (done),
    .fault         (fault),
    .fault_level   (fault_level),
    .paddr         (paddr),
    .perm          (perm)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Outer entry: invalid when p1 % 5 == 3; otherwise points at a per-p1 leaf table
  function automatic logic [31:0] outer_ent(input int p1);
    logic [31:0] e;
    if ((p1 % 5) == 3) e = (32'(p1) << 12) | 32'h0000_00FE;
    else e = LEAF_REGION + (32'(p1) << 12) + (32'(p1 % 8) << 1) + 32'h0000_0FF1;
    return e;
  endfunction

  // Inner entry: invalid when (p1 + p2) % 7 == 0
  function automatic logic [31:0] inner_ent(input int p1, input int p2);
    logic [31:0] e;
    logic [19:0] frm;
    frm = 20'((p1 * 37 + p2 * 11 + 5) & 32'h000F_FFFF);
    if (((p1 + p2) % 7) == 0) e = (32'(p2) << 12) | 32'h0000_0A0E;
    else e = {frm, 12'h0} | 32'h0000_0550 | (32'((p1 + p2) % 8) << 1) | 32'h1;
    return e;
  endfunction

  task automatic wait_resp(input int lat, input logic [31:0] exp_addr, input string tag);
    for (int i = 0; i < lat; i++) begin
      @(negedge clk);
      chk_eq({tag, " R10 read held"}, mem_rd_valid, 1);
      chk_eq({tag, " R10 addr stable"}, mem_rd_addr, exp_addr);
      chk_eq("R8 no pulse while reading", {done, fault}, 0);
    end
  endtask

  task automatic walk(input logic [31:0] va, input int lat, input bit poke);
    int p1, p2;
    logic [31:0] oe, ie, a_out, a_in;
    p1    = int'(va[31:22]);
    p2    = int'(va[21:12]);
    oe    = outer_ent(p1);
    ie    = inner_ent(p1, p2);
    a_out = tbl_base + 32'(p1 * 4);
    a_in  = {oe[31:12], 12'h000} + 32'(p2 * 4);

    @(negedge clk);
    chk_eq("R2 ready when idle", req_ready, 1);
    req_valid = 1'b1;
    req_vaddr = va;
    @(negedge clk);
    req_valid = poke;          // a request while busy must be ignored
    req_vaddr = ~va;
    chk_eq("R2 ready low while busy", req_ready, 0);
    chk_eq("R3 outer read valid", mem_rd_valid, 1);
    chk_eq("R3 outer read addr", mem_rd_addr, a_out);
    wait_resp(lat, a_out, "outer");
    mem_rsp_valid = 1'b1;
    mem_rsp_data  = oe;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = 32'hDEAD_BEEF;
    if (!oe[0]) begin
      chk_eq("R5 outer fault", fault, 1);
      chk_eq("R5 fault level outer", fault_level, 0);
      chk_eq("R5 no inner read", mem_rd_valid, 0);
      chk_eq("R8 no done with fault", done, 0);
    end else begin
      chk_eq("R4 inner read valid", mem_rd_valid, 1);
      chk_eq("R4 inner read addr", mem_rd_addr, a_in);
      chk_eq("R8 no pulse after outer", {done, fault}, 0);
      wait_resp(lat, a_in, "inner");
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = ie;
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      mem_rsp_data  = 32'hDEAD_BEEF;
      if (ie[0]) begin
        chk_eq("R7 done", done, 1);
        chk_eq("R7 paddr", paddr, {ie[31:12], va[11:0]});
        chk_eq("R7 perm", 32'(perm), 32'(ie[3:1]));
        chk_eq("R8 no fault with done", fault, 0);
      end else begin
        chk_eq("R6 inner fault", fault, 1);
        chk_eq("R6 fault level inner", fault_level, 1);
        chk_eq("R8 no done with fault", done, 0);
      end
    end
    @(negedge clk);
    req_valid = 1'b0;
    chk_eq("R8 pulse one cycle", {done, fault}, 0);
    chk_eq("R8 back to idle", req_ready, 1);
  endtask

  initial begin
    total = 0; bad = 0; finished = 0;
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_vaddr = '0;
    tbl_base = 32'h0000_8000;
    mem_rsp_valid = 1'b0;
    mem_rsp_data = '0;
    repeat (3) @(negedge clk);
    chk_eq("R1 reset ready", req_ready, 1);
    chk_eq("R1 reset no read", mem_rd_valid, 0);
    chk_eq("R1 reset no pulses", {done, fault}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_eq("R1 idle after reset", {req_ready, mem_rd_valid, done, fault}, 4'b1000);

    for (int b = 0; b < 2; b++) begin
      tbl_base = (b == 0) ? 32'h0000_8000 : 32'h0020_0404;
      for (int p1 = 0; p1 < 40; p1++) begin
        for (int k = 0; k < 3; k++) begin
          int p2;
          p2 = (k == 0) ? 0 : (k == 1) ? 1023 : ((p1 * 29 + 3) % 1024);
          walk({10'(p1), 10'(p2), 12'((p1 * 97 + k * 5) % 4096)}, (p1 + k) % 4, p1[0] ^ b[0]);
        end
      end
    end
    walk({10'd1023, 10'd1, 12'hFFF}, 2, 1'b1);
    walk({10'd1022, 10'd511, 12'h000}, 0, 1'b0);

    // R9: stray responses while idle change nothing
    begin
      logic [31:0] held;
      held = paddr;
      for (int i = 0; i < 3; i++) begin
        @(negedge clk);
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = 32'hABCD_E00F;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        chk_eq("R9 stray rsp no pulse", {done, fault}, 0);
        chk_eq("R9 stray rsp no read", mem_rd_valid, 0);
        chk_eq("R9 stray rsp paddr kept", paddr, held);
      end
    end
    walk({10'd1, 10'd2, 12'h123}, 1, 1'b0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule